// File: doc/BRIEF.md
# Next-PC and Link Unit

This unit decides where a 32-bit scalar core fetches next and whether the retiring instruction writes a return address into the register file. Each cycle the decode stage presents the current PC, a flow class, a branch condition, the 16-bit and 26-bit immediates, the two source operands, the destination field, and the values of the three saved return registers (exception return, break return and return address). When `valid_i` is high, the unit registers the next PC and any link write. Otherwise its outputs hold.

Absolute jumps stay inside the 256 MiB region of the current PC. Relative branches are word aligned: the two low offset bits are dropped. Three return flavours read three different saved registers. Only exception return raises a one-cycle strobe, which tells the control-register block to copy the saved status back into the live status register. Instruction fetch, register storage and exception entry are handled elsewhere.

Top module: `npc_link_unit`

## Requirements
- R1: While `rst_ni` is low, `npc_o` equals the `RESET_VEC` parameter, and `link_we_o` and `status_restore_o` are 0.
- R2: Class SEQ (code 0) gives `npc_o = pc + 4`, with no link write. Class codes 11 to 15 behave the same way.
- R3: Class JMPI (code 1) gives `npc_o = {pc[31:28], imm26, 2'b00}`.
- R4: Class BR (code 3) gives `npc_o = pc + 4 + (sign-extended imm16 with bits [1:0] cleared)`.
- R5: Class BCOND (code 4) compares operand A with operand B using `cond_i`: 0 signed >=, 1 signed <, 2 !=, 3 ==, 4 unsigned >=, 5 unsigned <. When the condition holds, the target is the R4 target. Otherwise, and for codes 6 and 7, `npc_o = pc + 4`.
- R6: Class CALL (code 2) writes `pc + 4` to register 31 and takes the R3 target.
- R7: Class CALLR (code 9) writes `pc + 4` to register 31 and sets `npc_o` to operand A.
- R8: Class RET (code 5) loads `npc_o` from `ra_i`, BRET (code 6) loads it from `ba_i`, and JMP (code 8) loads it from operand A. None of these writes a link.
- R9: Class ERET (code 7) loads `npc_o` from `ea_i` and raises `status_restore_o` for the following cycle only. No other class raises it.
- R10: Class NEXTPC (code 10) writes `pc + 4` to the register named by `rc_i` and sets `npc_o = pc + 4`. The write is suppressed when `rc_i` is 0.
- R11: When `valid_i` is low at a clock edge, `npc_o` keeps its value, and `link_we_o` and `status_restore_o` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction retires this cycle |
| pc_i | input | 32 | PC of the instruction |
| class_i | input | 4 | Flow class code |
| cond_i | input | 3 | Branch condition code |
| imm16_i | input | 16 | Branch offset immediate |
| imm26_i | input | 26 | Absolute jump immediate |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| rc_i | input | 5 | Destination register field |
| ea_i | input | 32 | Saved exception return address |
| ba_i | input | 32 | Saved break return address |
| ra_i | input | 32 | Return address register value |
| npc_o | output | 32 | Registered next PC |
| link_we_o | output | 1 | Link write enable |
| link_rd_o | output | 5 | Link destination register |
| link_data_o | output | 32 | Link write value |
| status_restore_o | output | 1 | One-cycle status restore strobe |

## Verification
The assertions check on every cycle the relations that one step of input fixes. These are: the hold and quiet outputs on idle cycles, sequential advance, the return-address link of both call forms, the suppressed write to register 0, and the exception-return strobe with its target. Region-relative jump targets, the aligned negative branch offsets, and the six comparisons at their signed and unsigned edges (all-ones against one) are checked only by the bench's vectors. The same holds for asynchronous reset in mid-run.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    FC_SEQ    = 4'd0,
    FC_JMPI   = 4'd1,
    FC_CALL   = 4'd2,
    FC_BR     = 4'd3,
    FC_BCOND  = 4'd4,
    FC_RET    = 4'd5,
    FC_BRET   = 4'd6,
    FC_ERET   = 4'd7,
    FC_JMP    = 4'd8,
    FC_CALLR  = 4'd9,
    FC_NEXTPC = 4'd10
  } flow_e;

  typedef enum logic [2:0] {
    CC_GE  = 3'd0,
    CC_LT  = 3'd1,
    CC_NE  = 3'd2,
    CC_EQ  = 3'd3,
    CC_GEU = 3'd4,
    CC_LTU = 3'd5
  } cond_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      cond_i,
  output logic            taken_o
);
  import npc_pkg::*;

  logic eq, slt, ult;
  assign eq  = (a_i == b_i);
  assign slt = ($signed(a_i) < $signed(b_i));
  assign ult = (a_i < b_i);

  always_comb begin
    case (cond_e'(cond_i))
      CC_GE:   taken_o = !slt;
      CC_LT:   taken_o = slt;
      CC_NE:   taken_o = !eq;
      CC_EQ:   taken_o = eq;
      CC_GEU:  taken_o = !ult;
      CC_LTU:  taken_o = ult;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN    = 32,
  parameter int IMM16_W = 16,
  parameter int IMM26_W = 26
) (
  input  npc_pkg::flow_e    cls_i,
  input  logic              taken_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IMM16_W-1:0] imm16_i,
  input  logic [IMM26_W-1:0] imm26_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   ea_i,
  input  logic [XLEN-1:0]   ba_i,
  input  logic [XLEN-1:0]   ra_i,
  output logic [XLEN-1:0]   seq_pc_o,
  output logic [XLEN-1:0]   npc_o
);
  import npc_pkg::*;

  localparam int REGION_LSB = IMM26_W + 2;
  localparam int SX_W       = XLEN - IMM16_W;

  logic [XLEN-1:0] off_sx, br_tgt, abs_tgt;

  assign seq_pc_o = pc_i + XLEN'(4);
  assign off_sx   = {{SX_W{imm16_i[IMM16_W-1]}}, imm16_i};
  // word-aligned offset: low bits discarded
  assign br_tgt   = seq_pc_o + (off_sx & ~XLEN'(3));
  assign abs_tgt  = {pc_i[XLEN-1:REGION_LSB], imm26_i, 2'b00};

  always_comb begin
    case (cls_i)
      FC_JMPI, FC_CALL: npc_o = abs_tgt;
      FC_BR:            npc_o = br_tgt;
      FC_BCOND:         npc_o = taken_i ? br_tgt : seq_pc_o;
      FC_RET:           npc_o = ra_i;
      FC_BRET:          npc_o = ba_i;
      FC_ERET:          npc_o = ea_i;
      FC_JMP, FC_CALLR: npc_o = opa_i;
      default:          npc_o = seq_pc_o;
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link #(
  parameter int XLEN   = 32,
  parameter int RW     = 5,
  parameter int RA_IDX = 31
) (
  input  npc_pkg::flow_e  cls_i,
  input  logic [RW-1:0]   rc_i,
  input  logic [XLEN-1:0] seq_pc_i,
  output logic            we_o,
  output logic [RW-1:0]   rd_o,
  output logic [XLEN-1:0] data_o
);
  import npc_pkg::*;

  assign data_o = seq_pc_i;

  always_comb begin
    we_o = 1'b0;
    rd_o = RW'(RA_IDX);
    case (cls_i)
      FC_CALL, FC_CALLR: we_o = 1'b1;
      FC_NEXTPC: begin
        rd_o = rc_i;
        we_o = (rc_i != '0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_link_unit.sv
module npc_link_unit #(
  parameter int          XLEN      = 32,
  parameter int          RW        = 5,
  parameter int          IMM16_W   = 16,
  parameter int          IMM26_W   = 26,
  parameter int          RA_IDX    = 31,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [3:0]        class_i,
  input  logic [2:0]        cond_i,
  input  logic [IMM16_W-1:0] imm16_i,
  input  logic [IMM26_W-1:0] imm26_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  input  logic [RW-1:0]     rc_i,
  input  logic [XLEN-1:0]   ea_i,
  input  logic [XLEN-1:0]   ba_i,
  input  logic [XLEN-1:0]   ra_i,
  output logic [XLEN-1:0]   npc_o,
  output logic              link_we_o,
  output logic [RW-1:0]     link_rd_o,
  output logic [XLEN-1:0]   link_data_o,
  output logic              status_restore_o
);
  import npc_pkg::*;

  flow_e           cls;
  logic            taken;
  logic [XLEN-1:0] seq_pc, npc_d, ldata_d;
  logic            lwe_d;
  logic [RW-1:0]   lrd_d;

  assign cls = flow_e'(class_i);

  npc_cond #(.XLEN(XLEN)) u_cond (
    .a_i(opa_i), .b_i(opb_i), .cond_i(cond_i), .taken_o(taken)
  );

  npc_target #(.XLEN(XLEN), .IMM16_W(IMM16_W), .IMM26_W(IMM26_W)) u_target (
    .cls_i(cls), .taken_i(taken), .pc_i(pc_i), .imm16_i(imm16_i),
    .imm26_i(imm26_i), .opa_i(opa_i), .ea_i(ea_i), .ba_i(ba_i),
    .ra_i(ra_i), .seq_pc_o(seq_pc), .npc_o(npc_d)
  );

  npc_link #(.XLEN(XLEN), .RW(RW), .RA_IDX(RA_IDX)) u_link (
    .cls_i(cls), .rc_i(rc_i), .seq_pc_i(seq_pc),
    .we_o(lwe_d), .rd_o(lrd_d), .data_o(ldata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npc_o            <= XLEN'(RESET_VEC);
      link_we_o        <= 1'b0;
      link_rd_o        <= '0;
      link_data_o      <= '0;
      status_restore_o <= 1'b0;
    end else if (valid_i) begin
      npc_o            <= npc_d;
      link_we_o        <= lwe_d;
      status_restore_o <= (cls == FC_ERET);
      if (lwe_d) begin
        link_rd_o   <= lrd_d;
        link_data_o <= ldata_d;
      end
    end else begin
      link_we_o        <= 1'b0;
      status_restore_o <= 1'b0;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(npc_o) && !link_we_o && !status_restore_o)); // R11
  AST_SEQ_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == FC_SEQ) |=> (npc_o == $past(pc_i) + XLEN'(4) && !link_we_o)); // R2
  AST_CALL_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (class_i == FC_CALL || class_i == FC_CALLR)) |=>
      (link_we_o && link_rd_o == RW'(RA_IDX) && link_data_o == $past(pc_i) + XLEN'(4))); // R6
  AST_CALLR_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == FC_CALLR) |=> (npc_o == $past(opa_i))); // R7
  AST_ZERO_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == FC_NEXTPC && rc_i == '0) |=> !link_we_o); // R10
  AST_ERET_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == FC_ERET) |=> (status_restore_o && npc_o == $past(ea_i))); // R9
  AST_STROBE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && class_i == FC_ERET) |=> !status_restore_o); // R9
endmodule

// File: tb/npc_link_unit_bench.sv
module npc_link_unit_bench;
  import npc_pkg::*;

  localparam logic [31:0] RV = 32'h0000_0020;
  localparam int NV = 21;

  typedef struct packed {
    logic [3:0]  cls;
    logic [2:0]  cnd;
    logic [31:0] pc;
    logic [15:0] imm16;
    logic [25:0] imm26;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [4:0]  rc;
    logic [31:0] enpc;
    logic        ewe;
    logic [4:0]  erd;
    logic [31:0] edata;
    logic        estb;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd0,  3'd0, 32'h0000_0100, 16'h0000, 26'h0,       32'h0,         32'h0, 5'd0, 32'h0000_0104, 1'b0, 5'd0,  32'h0,         1'b0, 4'd2},  // R2
    '{4'd15, 3'd0, 32'h0000_0200, 16'h0000, 26'h0,       32'h0,         32'h0, 5'd0, 32'h0000_0204, 1'b0, 5'd0,  32'h0,         1'b0, 4'd2},  // R2 unused code
    '{4'd1,  3'd0, 32'hA000_0010, 16'h0000, 26'h40,      32'h0,         32'h0, 5'd0, 32'hA000_0100, 1'b0, 5'd0,  32'h0,         1'b0, 4'd3},  // R3
    '{4'd1,  3'd0, 32'h5FFF_FFF0, 16'h0000, 26'h3FFFFFF, 32'h0,         32'h0, 5'd0, 32'h5FFF_FFFC, 1'b0, 5'd0,  32'h0,         1'b0, 4'd3},  // R3
    '{4'd3,  3'd0, 32'h0000_1000, 16'h0013, 26'h0,       32'h0,         32'h0, 5'd0, 32'h0000_1014, 1'b0, 5'd0,  32'h0,         1'b0, 4'd4},  // R4
    '{4'd3,  3'd0, 32'h0000_1000, 16'hFFF7, 26'h0,       32'h0,         32'h0, 5'd0, 32'h0000_0FF8, 1'b0, 5'd0,  32'h0,         1'b0, 4'd4},  // R4 negative
    '{4'd4,  3'd0, 32'h0000_2000, 16'h0020, 26'h0,       32'hFFFF_FFFF, 32'h1, 5'd0, 32'h0000_2004, 1'b0, 5'd0,  32'h0,         1'b0, 4'd5},  // R5 ge
    '{4'd4,  3'd1, 32'h0000_2000, 16'h0020, 26'h0,       32'hFFFF_FFFF, 32'h1, 5'd0, 32'h0000_2024, 1'b0, 5'd0,  32'h0,         1'b0, 4'd5},  // R5 lt
    '{4'd4,  3'd2, 32'h0000_2000, 16'h0020, 26'h0,       32'h5,         32'h5, 5'd0, 32'h0000_2004, 1'b0, 5'd0,  32'h0,         1'b0, 4'd5},  // R5 ne
    '{4'd4,  3'd3, 32'h0000_2000, 16'h0020, 26'h0,       32'h5,         32'h5, 5'd0, 32'h0000_2024, 1'b0, 5'd0,  32'h0,         1'b0, 4'd5},  // R5 eq
    '{4'd4,  3'd4, 32'h0000_2000, 16'h0020, 26'h0,       32'hFFFF_FFFF, 32'h1, 5'd0, 32'h0000_2024, 1'b0, 5'd0,  32'h0,         1'b0, 4'd5},  // R5 geu
    '{4'd4,  3'd5, 32'h0000_2000, 16'h0020, 26'h0,       32'hFFFF_FFFF, 32'h1, 5'd0, 32'h0000_2004, 1'b0, 5'd0,  32'h0,         1'b0, 4'd5},  // R5 ltu
    '{4'd4,  3'd6, 32'h0000_2000, 16'h0020, 26'h0,       32'h5,         32'h5, 5'd0, 32'h0000_2004, 1'b0, 5'd0,  32'h0,         1'b0, 4'd5},  // R5 unused cond
    '{4'd2,  3'd0, 32'h3000_0000, 16'h0000, 26'h10,      32'h0,         32'h0, 5'd0, 32'h3000_0040, 1'b1, 5'd31, 32'h3000_0004, 1'b0, 4'd6},  // R6
    '{4'd9,  3'd0, 32'h0000_0400, 16'h0000, 26'h0,       32'h0000_8888, 32'h0, 5'd0, 32'h0000_8888, 1'b1, 5'd31, 32'h0000_0404, 1'b0, 4'd7},  // R7
    '{4'd5,  3'd0, 32'h0000_0500, 16'h0000, 26'h0,       32'h0,         32'h0, 5'd0, 32'h0000_3000, 1'b0, 5'd0,  32'h0,         1'b0, 4'd8},  // R8 ret
    '{4'd6,  3'd0, 32'h0000_0500, 16'h0000, 26'h0,       32'h0,         32'h0, 5'd0, 32'h0000_2000, 1'b0, 5'd0,  32'h0,         1'b0, 4'd8},  // R8 bret
    '{4'd8,  3'd0, 32'h0000_0500, 16'h0000, 26'h0,       32'h0000_1234, 32'h0, 5'd0, 32'h0000_1234, 1'b0, 5'd0,  32'h0,         1'b0, 4'd8},  // R8 jmp
    '{4'd7,  3'd0, 32'h0000_0500, 16'h0000, 26'h0,       32'h0,         32'h0, 5'd0, 32'h0000_1000, 1'b0, 5'd0,  32'h0,         1'b1, 4'd9},  // R9
    '{4'd10, 3'd0, 32'h0000_0600, 16'h0000, 26'h0,       32'h0,         32'h0, 5'd7, 32'h0000_0604, 1'b1, 5'd7,  32'h0000_0604, 1'b0, 4'd10}, // R10
    '{4'd10, 3'd0, 32'h0000_0700, 16'h0000, 26'h0,       32'h0,         32'h0, 5'd0, 32'h0000_0704, 1'b0, 5'd0,  32'h0,         1'b0, 4'd10}  // R10 rc zero
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0;
  logic [3:0]  class_i = '0;
  logic [2:0]  cond_i = '0;
  logic [15:0] imm16_i = '0;
  logic [25:0] imm26_i = '0;
  logic [4:0]  rc_i = '0;
  logic [31:0] ea_i = 32'h0000_1000, ba_i = 32'h0000_2000, ra_i = 32'h0000_3000;
  logic [31:0] npc_o, link_data_o;
  logic        link_we_o, status_restore_o;
  logic [4:0]  link_rd_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  npc_link_unit #(.RESET_VEC(RV)) u_npc_link_unit (
    .clk_i, .rst_ni, .valid_i, .pc_i, .class_i, .cond_i, .imm16_i, .imm26_i,
    .opa_i, .opb_i, .rc_i, .ea_i, .ba_i, .ra_i, .npc_o, .link_we_o,
    .link_rd_o, .link_data_o, .status_restore_o
  );

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    class_i = v.cls; cond_i = v.cnd; pc_i = v.pc; imm16_i = v.imm16;
    imm26_i = v.imm26; opa_i = v.opa; opb_i = v.opb; rc_i = v.rc;
    valid_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check(1, "reset npc", npc_o, RV);
    check(1, "reset link_we", 32'(link_we_o), 0);
    check(1, "reset strobe", 32'(status_restore_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, "idle after reset npc", npc_o, RV);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk_i);
      check(int'(VECS[i].req), $sformatf("vec %0d npc", i), npc_o, VECS[i].enpc);
      check(int'(VECS[i].req), $sformatf("vec %0d link_we", i), 32'(link_we_o), 32'(VECS[i].ewe));
      check(int'(VECS[i].req), $sformatf("vec %0d strobe", i), 32'(status_restore_o), 32'(VECS[i].estb));
      if (VECS[i].ewe) begin
        check(int'(VECS[i].req), $sformatf("vec %0d link_rd", i), 32'(link_rd_o), 32'(VECS[i].erd));
        check(int'(VECS[i].req), $sformatf("vec %0d link_data", i), link_data_o, VECS[i].edata);
      end
    end

    // R11 idle with a call presented: nothing changes
    drive(VECS[13]);
    @(negedge clk_i);
    held = npc_o;
    class_i = 4'd2; pc_i = 32'h7000_0000; imm26_i = 26'h55; valid_i = 1'b0;
    @(negedge clk_i);
    check(11, "idle npc hold", npc_o, held);
    check(11, "idle link_we", 32'(link_we_o), 0);

    // R9 strobe lasts one cycle; R11 idle after eret
    drive(VECS[18]);
    @(negedge clk_i);
    check(9, "eret strobe", 32'(status_restore_o), 1);
    valid_i = 1'b0;
    @(negedge clk_i);
    check(9, "strobe drops", 32'(status_restore_o), 0);
    check(11, "npc hold after eret", npc_o, 32'h0000_1000);

    // R9 back-to-back eret then seq
    drive(VECS[18]);
    @(negedge clk_i);
    drive(VECS[0]);
    @(negedge clk_i);
    check(9, "no strobe on seq", 32'(status_restore_o), 0);
    check(2, "seq after eret", npc_o, 32'h0000_0104);

    // R1 asynchronous reset mid-run
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #3;
    check(1, "async reset npc", npc_o, RV);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule